// File: doc/BRIEF.md
# Gated Pulse Accumulator

The block counts activity on one external input pin in a 16-bit accumulator. Event mode counts one chosen edge (rising or falling) of the input. Gated mode counts ticks of a divide-by-64 prescaler strobe while the input sits at a chosen active level. When the active phase ends, the edge that ends it raises an input-edge flag. A counter rollover raises an overflow flag. Each flag has its own interrupt enable. The single interrupt output is the OR of the enabled flags.

The block also picks the count strobe for a neighbouring timer counter. The choices are the prescaler strobe, the accumulator strobe itself, or the accumulator strobe divided by 256 or by 65536. The two divided strobes come from the counter's own low-byte and full-width rollovers. Every strobe is a one-cycle enable in the system clock domain. The input pin passes through a two-flop synchroniser.

A small state machine holds the operating phase. The states are ST_OFF (disabled), ST_EVENT (edge counting), ST_GATE_WAIT (gated mode, input inactive) and ST_GATE_RUN (gated mode, input active). The transitions are:
- Any state goes to ST_OFF when the enable is cleared.
- Any state goes to ST_EVENT when the block is enabled with mode 0.
- ST_OFF or ST_EVENT goes to ST_GATE_RUN or ST_GATE_WAIT when mode 1 is selected, depending on the input level.
- ST_GATE_WAIT goes to ST_GATE_RUN when the input becomes active.
- ST_GATE_RUN goes to ST_GATE_WAIT on the trailing edge, and that edge sets the input-edge flag.

Top module: `pulse_acc`

## Requirements
- R1: The control register resets to 0x00 and reads back on `ctl_rdata` with bit 7 always 0. Its fields are: bit 6 enable, bit 5 mode (0 event, 1 gated), bit 4 polarity, bits 3:2 clock select, bit 1 overflow interrupt enable, bit 0 edge interrupt enable.
- R2: While the enable bit is 0, the counter does not change except through a load.
- R3: In event mode, polarity 1 counts rising input edges and polarity 0 counts falling edges. Each counted edge also sets the edge flag (`flags_q` bit 0).
- R4: In gated mode, polarity 0 counts `div64_tick` strobes while the input is high, and the falling edge sets the edge flag. Polarity 1 counts while the input is low, and the rising edge sets the flag. Strobes during the inactive level are not counted.
- R5: Gated counting needs `tmr_en` high. Event counting works with `tmr_en` low.
- R6: An increment from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (`flags_q` bit 1).
- R7: Writing 1 to a bit through `flag_clr_wr`/`flag_clr_data` clears that flag (bit 1 overflow, bit 0 edge). Writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some flag is set together with its enable bit.
- R9: `tmr_clk_en` follows the clock select: 00 gives `presc_tick`, 01 gives each accumulator increment, 10 gives one strobe per low-byte rollover (xxFF to next), and 11 gives one strobe per 0xFFFF rollover. With the enable bit 0, `presc_tick` is used whatever the select.
- R10: A new clock select drives `tmr_clk_en` in the same cycle the register holds it, with no extra register stage.
- R11: An input change reaches the counter through two synchroniser flops. The counter shows the count two clock cycles after the first rising clock edge that samples the new pin level, not earlier.
- R12: A `cnt_wr` write loads `cnt_wdata` into the counter on the next edge and takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External accumulator input (asynchronous) |
| tmr_en | input | 1 | Main timer running; qualifies gated counting |
| div64_tick | input | 1 | Divide-by-64 prescaler strobe |
| presc_tick | input | 1 | Timer prescaler strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_data | input | 2 | Write-1-to-clear mask {overflow, edge} |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cnt_q | output | CNT_W | Accumulator value |
| flags_q | output | 2 | {overflow flag, edge flag} |
| irq | output | 1 | Interrupt request |
| tmr_clk_en | output | 1 | Count strobe for the timer counter |

## Verification
On every cycle, the in-RTL assertions check the following:
- the counter holds while disabled;
- gated increments coincide with a divide-by-64 strobe and a running timer;
- a wrap from all-ones sets the overflow flag, and write-1-to-clear removes it;
- a load lands on the next edge;
- a disabled block passes the prescaler strobe through;
- the interrupt never rises without an enabled flag.

Only the bench scenarios can show the rest:
- that the right edge polarity and active level are chosen;
- that the trailing edge, not the leading one, sets the flag;
- the exact two-flop latency;
- the divide-by-256 and divide-by-65536 strobe counts;
- that a select change acts on the clock output in the same cycle.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_WAIT = 2'd2,
        ST_GATE_RUN  = 2'd3
    } pa_state_e;

    typedef enum logic [1:0] {
        SEL_PRESC = 2'b00,
        SEL_ACC   = 2'b01,
        SEL_MID   = 2'b10,
        SEL_FULL  = 2'b11
    } pa_sel_e;

    // Field order matches control bits 6..0
    typedef struct packed {
        logic    en;
        logic    mode;
        logic    pol;
        pa_sel_e sel;
        logic    ie_ovf;
        logic    ie_edg;
    } pa_ctl_t;

    localparam int CTL_W  = 8;
    localparam int FLAG_W = 2;

endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/pa_ctrl_fsm.sv
module pa_ctrl_fsm
    import pa_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pa_ctl_t ctl,
    input  logic    lvl,
    input  logic    rise,
    input  logic    fall,
    input  logic    tmr_en,
    input  logic    div64_tick,
    output logic    acc_tick,
    output logic    edge_set
);
    pa_state_e state_q, state_d;
    logic      active;
    logic      trail;

    assign active = ctl.pol ? ~lvl : lvl;
    assign trail  = ctl.pol ? rise : fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!ctl.en) begin
            state_d = ST_OFF;
        end else if (!ctl.mode) begin
            state_d = ST_EVENT;
        end else begin
            unique case (state_q)
                ST_OFF, ST_EVENT: state_d = active ? ST_GATE_RUN : ST_GATE_WAIT;
                ST_GATE_WAIT:     if (active)  state_d = ST_GATE_RUN;
                ST_GATE_RUN:      if (!active) state_d = ST_GATE_WAIT;
                default:          state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        acc_tick = 1'b0;
        edge_set = 1'b0;
        unique case (state_q)
            ST_EVENT: begin
                if (ctl.en && !ctl.mode) begin
                    acc_tick = ctl.pol ? rise : fall;
                    edge_set = ctl.pol ? rise : fall;
                end
            end
            ST_GATE_RUN: begin
                if (ctl.en && ctl.mode) begin
                    acc_tick = active && tmr_en && div64_tick;
                    edge_set = trail;
                end
            end
            ST_OFF, ST_GATE_WAIT: begin
                acc_tick = 1'b0;
                edge_set = 1'b0;
            end
            default: begin
                acc_tick = 1'b0;
                edge_set = 1'b0;
            end
        endcase
    end

    AST_GATE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE_RUN && acc_tick) |-> (tmr_en && div64_tick)); // R5

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!acc_tick && !edge_set)); // R2

endmodule

// File: rtl/pa_counter.sv
module pa_counter
    import pa_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int MID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              acc_tick,
    input  logic              edge_set,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              flag_clr_wr,
    input  logic [FLAG_W-1:0] flag_clr,
    input  logic              ie_ovf,
    input  logic              ie_edg,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf_flag,
    output logic              edg_flag,
    output logic              irq,
    output logic              mid_wrap,
    output logic              full_wrap
);
    logic inc;

    assign inc       = acc_tick && !cnt_wr;
    assign mid_wrap  = inc && (&cnt[MID_W-1:0]);
    assign full_wrap = inc && (&cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= cnt_wdata;
        else if (inc)    cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            edg_flag <= 1'b0;
        end else begin
            if (full_wrap)                       ovf_flag <= 1'b1;
            else if (flag_clr_wr && flag_clr[1]) ovf_flag <= 1'b0;
            if (edge_set)                        edg_flag <= 1'b1;
            else if (flag_clr_wr && flag_clr[0]) edg_flag <= 1'b0;
        end
    end

    assign irq = (ovf_flag && ie_ovf) || (edg_flag && ie_edg);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt)); // R2

    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_tick && !cnt_wr && (&cnt)) |=> (ovf_flag && cnt == '0)); // R6

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata))); // R12

    AST_W1C_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_wr && flag_clr[1] && !full_wrap) |=> !ovf_flag); // R7

endmodule

// File: rtl/pa_clk_sel.sv
module pa_clk_sel
    import pa_pkg::*;
(
    input  logic    en,
    input  pa_sel_e sel,
    input  logic    presc_tick,
    input  logic    acc_tick,
    input  logic    mid_wrap,
    input  logic    full_wrap,
    output logic    tmr_clk_en
);
    always_comb begin
        if (!en) begin
            tmr_clk_en = presc_tick;
        end else begin
            unique case (sel)
                SEL_PRESC: tmr_clk_en = presc_tick;
                SEL_ACC:   tmr_clk_en = acc_tick;
                SEL_MID:   tmr_clk_en = mid_wrap;
                SEL_FULL:  tmr_clk_en = full_wrap;
                default:   tmr_clk_en = presc_tick;
            endcase
        end
    end
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
    import pa_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MID_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              tmr_en,
    input  logic              div64_tick,
    input  logic              presc_tick,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              flag_clr_wr,
    input  logic [FLAG_W-1:0] flag_clr_data,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic              irq,
    output logic              tmr_clk_en
);
    pa_ctl_t ctl_q;
    logic    lvl, rise, fall;
    logic    acc_tick, edge_set;
    logic    ovf_flag, edg_flag;
    logic    mid_wrap, full_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= pa_ctl_t'(ctl_wdata[CTL_W-2:0]);
    end

    assign ctl_rdata = {1'b0, ctl_q};
    assign flags_q   = {ovf_flag, edg_flag};

    pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    pa_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl_q),
        .lvl       (lvl),
        .rise      (rise),
        .fall      (fall),
        .tmr_en    (tmr_en),
        .div64_tick(div64_tick),
        .acc_tick  (acc_tick),
        .edge_set  (edge_set)
    );

    pa_counter #(.CNT_W(CNT_W), .MID_W(MID_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctl_q.en),
        .acc_tick   (acc_tick),
        .edge_set   (edge_set),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .flag_clr_wr(flag_clr_wr),
        .flag_clr   (flag_clr_data),
        .ie_ovf     (ctl_q.ie_ovf),
        .ie_edg     (ctl_q.ie_edg),
        .cnt        (cnt_q),
        .ovf_flag   (ovf_flag),
        .edg_flag   (edg_flag),
        .irq        (irq),
        .mid_wrap   (mid_wrap),
        .full_wrap  (full_wrap)
    );

    pa_clk_sel u_sel (
        .en        (ctl_q.en),
        .sel       (ctl_q.sel),
        .presc_tick(presc_tick),
        .acc_tick  (acc_tick),
        .mid_wrap  (mid_wrap),
        .full_wrap (full_wrap),
        .tmr_clk_en(tmr_clk_en)
    );

    AST_OFF_USES_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.en |-> (tmr_clk_en == presc_tick)); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags_q & {ctl_q.ie_ovf, ctl_q.ie_edg}) != '0)); // R8

endmodule

// File: tb/sim_pulse_acc.sv
module sim_pulse_acc;
    localparam int CNT_W = 16;

    localparam int K_CNT   = 0;
    localparam int K_FLAGS = 1;
    localparam int K_IRQ   = 2;
    localparam int K_CTL   = 3;
    localparam int K_TCNT  = 4;
    localparam int K_TLVL  = 5;

    typedef struct {
        string req;
        int    kind;
        int    exp;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_in = 1'b0;
    logic             tmr_en = 1'b0;
    logic             div64_tick = 1'b0;
    logic             presc_tick = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [7:0]       ctl_wdata = '0;
    logic [7:0]       ctl_rdata;
    logic             flag_clr_wr = 1'b0;
    logic [1:0]       flag_clr_data = '0;
    logic             cnt_wr = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       flags_q;
    logic             irq;
    logic             tmr_clk_en;

    int    checks = 0;
    int    fails = 0;
    int    tclk_cnt = 0;
    int    tclk_base = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    event  ev_chk;

    always #2 clk = ~clk;

    pulse_acc #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tmr_en(tmr_en),
        .div64_tick(div64_tick), .presc_tick(presc_tick),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .flag_clr_wr(flag_clr_wr), .flag_clr_data(flag_clr_data),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .flags_q(flags_q), .irq(irq), .tmr_clk_en(tmr_clk_en)
    );

    always @(negedge clk) if (tmr_clk_en === 1'b1) tclk_cnt <= tclk_cnt + 1;

    function automatic int sample(int kind);
        case (kind)
            K_CNT:   return int'(cnt_q);
            K_FLAGS: return int'(flags_q);
            K_IRQ:   return int'(irq);
            K_CTL:   return int'(ctl_rdata);
            K_TCNT:  return tclk_cnt - tclk_base;
            default: return int'(tmr_clk_en);
        endcase
    endfunction

    // Monitor: pops expected items and compares against design outputs
    initial begin
        forever begin
            @(ev_chk);
            while (sb_q.size() > 0) begin
                item_t it;
                int    act;
                it  = sb_q.pop_front();
                act = sample(it.kind);
                checks++;
                if (act != it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string req, int kind, int exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb_q.push_back(it);
        -> ev_chk;
        #1;
    endtask

    task automatic wr_ctl(logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_flags(logic [1:0] v);
        @(negedge clk); flag_clr_wr = 1'b1; flag_clr_data = v;
        @(negedge clk); flag_clr_wr = 1'b0;
    endtask

    task automatic ld_cnt(logic [CNT_W-1:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic set_pin(logic v);
        @(negedge clk); pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
    endtask

    task automatic gate_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); div64_tick = 1'b1;
            @(negedge clk); div64_tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic presc_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); presc_tick = 1'b1;
            @(negedge clk); presc_tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic mark_tclk();
        @(negedge clk); #1;
        tclk_base = tclk_cnt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val("R1 ctl reset", K_CTL, 'h00);
        expect_val("R1 cnt reset", K_CNT, 0);
        expect_val("R1 flags reset", K_FLAGS, 0);
        expect_val("R8 irq reset", K_IRQ, 0);

        wr_ctl(8'hFF);
        expect_val("R1 reserved bit7 zero", K_CTL, 'h7F);
        wr_ctl(8'h00);
        expect_val("R1 ctl cleared", K_CTL, 'h00);

        // Event mode, rising edges, timer off
        wr_ctl(8'h50);
        pulses(3);
        expect_val("R3 R5 rising edges counted", K_CNT, 3);
        expect_val("R3 edge flag on counted edge", K_FLAGS, 1);
        expect_val("R8 irq masked", K_IRQ, 0);
        wr_ctl(8'h51);
        expect_val("R8 irq on edge flag", K_IRQ, 1);
        wr_flags(2'b01);
        expect_val("R7 edge flag cleared", K_FLAGS, 0);
        expect_val("R8 irq drops", K_IRQ, 0);

        // Falling edges
        wr_ctl(8'h40);
        pulses(2);
        expect_val("R3 falling edges counted", K_CNT, 5);

        // Synchroniser latency
        wr_ctl(8'h50);
        @(negedge clk); pin_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        expect_val("R11 not yet counted", K_CNT, 5);
        @(negedge clk);
        expect_val("R11 counted after two flops", K_CNT, 6);
        set_pin(1'b0);

        // Disabled
        wr_ctl(8'h00);
        pulses(2);
        expect_val("R2 disabled holds", K_CNT, 6);

        // Load and overflow
        ld_cnt(16'hFFFE);
        expect_val("R12 load", K_CNT, 'hFFFE);
        wr_flags(2'b11);
        wr_ctl(8'h52);
        pulses(2);
        expect_val("R6 wrap to zero", K_CNT, 0);
        expect_val("R6 overflow flag", K_FLAGS, 3);
        expect_val("R8 irq on overflow", K_IRQ, 1);
        wr_flags(2'b10);
        expect_val("R7 only overflow cleared", K_FLAGS, 1);
        expect_val("R8 irq off after clear", K_IRQ, 0);
        wr_flags(2'b01);

        // Gated, active high
        ld_cnt('0);
        tmr_en = 1'b1;
        wr_ctl(8'h60);
        set_pin(1'b1);
        gate_ticks(4);
        expect_val("R4 gated counts while high", K_CNT, 4);
        expect_val("R4 no flag on leading edge", K_FLAGS, 0);
        set_pin(1'b0);
        expect_val("R4 trailing fall sets flag", K_FLAGS, 1);
        gate_ticks(3);
        expect_val("R4 inactive level ignored", K_CNT, 4);
        wr_flags(2'b01);

        // Gated needs timer
        set_pin(1'b1);
        tmr_en = 1'b0;
        gate_ticks(3);
        expect_val("R5 gated idle without timer", K_CNT, 4);
        tmr_en = 1'b1;
        gate_ticks(2);
        expect_val("R5 gated resumes with timer", K_CNT, 6);
        set_pin(1'b0);
        wr_flags(2'b01);

        // Gated, active low
        wr_ctl(8'h70);
        repeat (3) @(negedge clk);
        gate_ticks(2);
        expect_val("R4 active low counts", K_CNT, 8);
        set_pin(1'b1);
        expect_val("R4 trailing rise sets flag", K_FLAGS, 1);
        gate_ticks(2);
        expect_val("R4 high ignored with polarity 1", K_CNT, 8);
        set_pin(1'b0);
        wr_flags(2'b01);
        tmr_en = 1'b0;

        // Clock select
        wr_ctl(8'h0C);
        mark_tclk();
        presc_ticks(3);
        expect_val("R9 disabled uses prescaler", K_TCNT, 3);

        wr_ctl(8'h54);
        mark_tclk();
        pulses(3);
        presc_ticks(2);
        expect_val("R9 select 01 accumulator strobe", K_TCNT, 3);

        ld_cnt(16'h00FE);
        wr_ctl(8'h58);
        mark_tclk();
        pulses(3);
        expect_val("R9 select 10 low-byte wrap", K_TCNT, 1);
        expect_val("R9 count after low-byte wrap", K_CNT, 'h0101);

        ld_cnt(16'hFFFE);
        wr_ctl(8'h5C);
        mark_tclk();
        pulses(3);
        expect_val("R9 select 11 full wrap", K_TCNT, 1);

        wr_ctl(8'h50);
        mark_tclk();
        presc_ticks(2);
        expect_val("R9 select 00 prescaler", K_TCNT, 2);

        // Immediate select change
        @(negedge clk); presc_tick = 1'b1;
        #1;
        expect_val("R10 prescaler passes", K_TLVL, 1);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'h54;
        @(negedge clk); ctl_wr = 1'b0;
        #1;
        expect_val("R10 select acts same cycle", K_TLVL, 0);
        presc_tick = 1'b0;

        repeat (2) @(negedge clk);
        -> ev_chk;
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule